// File: doc/BRIEF.md
# SPI Client Address Filter

This block sits behind the receive shifter of an SPI client whose frames open with an address character. When the select line falls, the block waits for the first completed character. It treats that character as the frame's address and compares it against two configuration values, a reference address and an auxiliary value. One of three comparison modes applies: masked equality, either of two exact addresses, or an inclusive window. The outcome is registered as a match flag.

The flag holds until the select line returns high. While a matching frame is open, every later character is forwarded through a data strobe. A frame that did not match has all of its remaining characters suppressed. The address character itself is never forwarded. The flag is cleared when the frame ends, so the next frame starts undecided.

Top module: `spi_addr_filter`

## Requirements
- R1: After reset, `match_o`, `decided_o` and `data_valid_o` are all 0.
- R2: With `mode_i` = 0 (masked), a bit set to 1 in `aux_i` is excluded from the comparison. The address matches when every remaining bit equals the same bit of `ref_i`.
- R3: With `mode_i` = 1 (pair), the address matches when it equals `ref_i` or equals `aux_i`.
- R4: With `mode_i` = 2 (window), the address matches when `aux_i` <= address <= `ref_i`, both bounds included and compared unsigned.
- R5: With `mode_i` = 3 (reserved), no address ever matches.
- R6: Only the first character accepted after `cs_n` falls is compared. Later characters, and later changes of `mode_i`, `ref_i` or `aux_i`, leave `match_o` unchanged until the frame ends.
- R7: One cycle after `cs_n` is sampled high, `match_o` and `decided_o` are 0. Characters that arrive while `cs_n` is high are ignored and do not set `decided_o`.
- R8: `data_valid_o` is 1 in the same cycle as `rx_valid_i` only for a character after the address in a matching frame. `data_o` then equals `rx_char_i`. The address character is never forwarded.
- R9: `decided_o` and `match_o` take the result of the address character from the clock edge on which that character is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Client select, active low, already synchronous to clk |
| rx_valid_i | input | 1 | One-cycle strobe for a completed received character |
| rx_char_i | input | AW | Received character |
| mode_i | input | 2 | Match mode: 0 masked, 1 pair, 2 window, 3 reserved |
| ref_i | input | AW | Reference address; upper bound in window mode |
| aux_i | input | AW | Mask, second address, or lower bound, depending on mode |
| match_o | output | 1 | Frame address matched |
| decided_o | output | 1 | Address of the current frame has been evaluated |
| data_valid_o | output | 1 | Forwarded character strobe |
| data_o | output | AW | Forwarded character |

## Verification
The forwarding strobe is combinational from the character strobe and the registered flag. The bench therefore checks it in the same cycle it raises `rx_valid_i`, after a short settling delay from the falling edge. The match and decided flags are due one rising edge after the address character or the select rise. The bench reads them at the following falling edge, never at the edge itself. Inputs are driven only on falling edges, so each result is checked exactly one half-period after the edge that produces it.

// File: rtl/addr_filt_pkg.sv
package addr_filt_pkg;
    typedef enum logic [1:0] {
        MM_MASKED = 2'd0,
        MM_PAIR   = 2'd1,
        MM_WINDOW = 2'd2,
        MM_RSVD   = 2'd3
    } match_mode_e;

    typedef struct packed {
        logic decided;
        logic hit;
    } frame_state_t;
endpackage

// File: rtl/addr_filt_cmp.sv
module addr_filt_cmp #(
    parameter int AW = 8
) (
    input  logic [1:0]    mode_i,
    input  logic [AW-1:0] addr_i,
    input  logic [AW-1:0] ref_i,
    input  logic [AW-1:0] aux_i,
    output logic          hit_o
);
    import addr_filt_pkg::*;

    logic [AW-1:0] bit_ok;
    logic          masked_ok;
    logic          pair_ok;
    logic          window_ok;

    // per-bit masked equality: aux bit set means "don't care"
    for (genvar i = 0; i < AW; i++) begin : g_bit
        assign bit_ok[i] = aux_i[i] | (addr_i[i] ~^ ref_i[i]);
    end

    assign masked_ok = &bit_ok;
    assign pair_ok   = (addr_i == ref_i) | (addr_i == aux_i);
    assign window_ok = (addr_i <= ref_i) & (addr_i >= aux_i);

    always_comb begin
        unique case (match_mode_e'(mode_i))
            MM_MASKED: hit_o = masked_ok;
            MM_PAIR:   hit_o = pair_ok;
            MM_WINDOW: hit_o = window_ok;
            default:   hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/addr_filt_frame.sv
module addr_filt_frame (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n,
    input  logic rx_valid_i,
    input  logic cmp_hit_i,
    output logic decided_o,
    output logic hit_o
);
    import addr_filt_pkg::*;

    frame_state_t st_d;
    frame_state_t st_q;

    always_comb begin
        st_d = st_q;
        if (cs_n) begin
            st_d.decided = 1'b0;
            st_d.hit     = 1'b0;
        end else if (rx_valid_i && !st_q.decided) begin
            st_d.decided = 1'b1;
            st_d.hit     = cmp_hit_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign decided_o = st_q.decided;
    assign hit_o     = st_q.hit;
endmodule

// File: rtl/spi_addr_filter.sv
module spi_addr_filter #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cs_n,
    input  logic          rx_valid_i,
    input  logic [AW-1:0] rx_char_i,
    input  logic [1:0]    mode_i,
    input  logic [AW-1:0] ref_i,
    input  logic [AW-1:0] aux_i,
    output logic          match_o,
    output logic          decided_o,
    output logic          data_valid_o,
    output logic [AW-1:0] data_o
);
    logic cmp_hit;
    logic decided_q;
    logic hit_q;

    addr_filt_cmp #(.AW(AW)) u_cmp (
        .mode_i (mode_i),
        .addr_i (rx_char_i),
        .ref_i  (ref_i),
        .aux_i  (aux_i),
        .hit_o  (cmp_hit)
    );

    addr_filt_frame u_frame (
        .clk        (clk),
        .rst_n      (rst_n),
        .cs_n       (cs_n),
        .rx_valid_i (rx_valid_i),
        .cmp_hit_i  (cmp_hit),
        .decided_o  (decided_q),
        .hit_o      (hit_q)
    );

    assign match_o      = hit_q;
    assign decided_o    = decided_q;
    assign data_valid_o = rx_valid_i & ~cs_n & decided_q & hit_q;
    assign data_o       = rx_char_i;
endmodule

// File: rtl/spi_addr_filter_chk.sv
module spi_addr_filter_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       rx_valid_i,
    input logic [1:0] mode_i,
    input logic       match_o,
    input logic       decided_o,
    input logic       data_valid_o
);
    // R5: a decision taken under the reserved mode is never a match
    a_r5_reserved_miss: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rx_valid_i && !decided_o && mode_i == 2'd3) |=> !match_o);

    // R6: once decided inside an open frame, the flag does not move
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (decided_o && !cs_n) |=> ($stable(match_o) && decided_o));

    // R7: select high clears the frame state on the next edge
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!match_o && !decided_o));

    // R8: forwarding only within a decided, matching frame
    a_r8_gate: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid_o |-> (match_o && decided_o && rx_valid_i && !cs_n));

    // R8: the address character itself is never forwarded
    a_r8_no_addr_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid_i && !decided_o) |-> !data_valid_o);

    // R9: an accepted address character marks the frame decided on the next edge
    a_r9_decide: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && rx_valid_i) |=> decided_o);
endmodule

bind spi_addr_filter spi_addr_filter_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cs_n         (cs_n),
    .rx_valid_i   (rx_valid_i),
    .mode_i       (mode_i),
    .match_o      (match_o),
    .decided_o    (decided_o),
    .data_valid_o (data_valid_o)
);

// File: tb/sim_spi_addr_filter.sv
module sim_spi_addr_filter;
    localparam int AW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cs_n = 1'b1;
    logic          rx_valid_i = 1'b0;
    logic [AW-1:0] rx_char_i = '0;
    logic [1:0]    mode_i = 2'd0;
    logic [AW-1:0] ref_i = '0;
    logic [AW-1:0] aux_i = '0;
    logic          match_o;
    logic          decided_o;
    logic          data_valid_o;
    logic [AW-1:0] data_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    spi_addr_filter #(.AW(AW)) u0 (.*);

    function automatic bit model(input logic [1:0] m, input logic [AW-1:0] a,
                                 input logic [AW-1:0] r, input logic [AW-1:0] x);
        case (m)
            2'd0: return ((a ^ r) & ~x) == '0;
            2'd1: return (a == r) || (a == x);
            2'd2: return (a >= x) && (a <= r);
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic open_frame();
        @(negedge clk); cs_n = 1'b0;
    endtask

    task automatic close_frame(input string req);
        @(negedge clk); cs_n = 1'b1;
        @(negedge clk);
        check(req, {30'd0, decided_o, match_o}, 32'd0);
    endtask

    // drive one character; check forwarding in-cycle, return after the edge
    task automatic put_char(input logic [AW-1:0] c, input bit exp_fwd, input string req);
        @(negedge clk); rx_valid_i = 1'b1; rx_char_i = c;
        #1;
        check(req, {31'd0, data_valid_o}, {31'd0, exp_fwd});
        if (exp_fwd) check(req, {24'd0, data_o}, {24'd0, c});
        @(negedge clk); rx_valid_i = 1'b0;
    endtask

    task automatic one_frame(input logic [1:0] m, input logic [AW-1:0] a,
                             input logic [AW-1:0] r, input logic [AW-1:0] x, input string req);
        bit e;
        mode_i = m; ref_i = r; aux_i = x;
        e = model(m, a, r, x);
        open_frame();
        put_char(a, 1'b0, req);
        check(req, {30'd0, decided_o, match_o}, {30'd0, 1'b1, e});
        put_char(8'h5A, e, req);
        close_frame("R7");
    endtask

    task automatic t_reset();
        check("R1", {29'd0, match_o, decided_o, data_valid_o}, 32'd0);
    endtask

    task automatic t_masked();
        one_frame(2'd0, 8'hA5, 8'hA5, 8'h00, "R2");
        one_frame(2'd0, 8'hA4, 8'hA5, 8'h00, "R2");
        one_frame(2'd0, 8'hAF, 8'hA0, 8'h0F, "R2");
        one_frame(2'd0, 8'hB0, 8'hA0, 8'h0F, "R2");
    endtask

    task automatic t_pair();
        one_frame(2'd1, 8'h12, 8'h12, 8'h34, "R3");
        one_frame(2'd1, 8'h34, 8'h12, 8'h34, "R3");
        one_frame(2'd1, 8'h13, 8'h12, 8'h34, "R3");
    endtask

    task automatic t_window();
        one_frame(2'd2, 8'h40, 8'h60, 8'h40, "R4");
        one_frame(2'd2, 8'h60, 8'h60, 8'h40, "R4");
        one_frame(2'd2, 8'h50, 8'h60, 8'h40, "R4");
        one_frame(2'd2, 8'h3F, 8'h60, 8'h40, "R4");
        one_frame(2'd2, 8'h61, 8'h60, 8'h40, "R4");
    endtask

    task automatic t_reserved();
        one_frame(2'd3, 8'h00, 8'h00, 8'h00, "R5");
        one_frame(2'd3, 8'h77, 8'h77, 8'hFF, "R5");
    endtask

    task automatic t_first_only();
        mode_i = 2'd1; ref_i = 8'h21; aux_i = 8'h22;
        open_frame();
        put_char(8'h99, 1'b0, "R6");
        check("R6", {31'd0, match_o}, 32'd0);
        put_char(8'h21, 1'b0, "R6");
        check("R6", {31'd0, match_o}, 32'd0);
        close_frame("R7");
        open_frame();
        put_char(8'h21, 1'b0, "R9");
        check("R9", {30'd0, decided_o, match_o}, 32'd3);
        mode_i = 2'd3; ref_i = 8'h00; aux_i = 8'h00;
        put_char(8'h44, 1'b1, "R6");
        check("R6", {31'd0, match_o}, 32'd1);
        close_frame("R7");
    endtask

    task automatic t_idle_chars();
        mode_i = 2'd1; ref_i = 8'h10; aux_i = 8'h10;
        put_char(8'h10, 1'b0, "R7");
        check("R7", {30'd0, decided_o, match_o}, 32'd0);
        open_frame();
        put_char(8'h11, 1'b0, "R8");
        put_char(8'h10, 1'b0, "R8");
        put_char(8'h10, 1'b0, "R8");
        check("R8", {31'd0, match_o}, 32'd0);
        close_frame("R7");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_masked();
        t_pair();
        t_window();
        t_reserved();
        t_first_only();
        t_idle_chars();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule